// File: doc/BRIEF.md
# Adder-Tree Majority Voter

This block takes an odd-width bit vector of 2^K − 1 bits and reports which value holds the majority. It builds that answer only from 1-bit full adders arranged in K levels. The first level reduces the raw input bits. Every carry produced on one level becomes an input bit of weight two on the next level. Inside a level the adders form a chain: each adder's sum feeds the next adder along.

The last sum of each level is one bit of the binary population count. With an input width of 2^K − 1, the most significant count bit is set exactly when more than half the inputs are 1, so that bit is the majority. No magnitude comparator is involved.

The full count is brought out as well. A flag marks inputs that are strongly skewed, meaning at least three quarters of the bits share one value. The result can be registered behind an input strobe, or it can pass straight through combinationally. The choice is made by a parameter.

Top module: `fa_tree_majority`

## Requirements
- R1: With N = 2^K − 1 input bits (K ≥ 2), `count_o` equals the number of 1s in the presented `data_i`. Bit j−1 of `count_o` is the final sum bit of level j.
- R2: Every full adder computes s = x ^ y ^ cin and cout = (x & y) | (cin & (x ^ y)), using two XOR, two AND and one OR gate.
- R3: A level of width W chains (W−1)/2 adders. The first adder takes three input bits. Each later adder takes two new bits plus the previous adder's sum. Its (W−1)/2 carries form the next level's input, so the level's 1s equal its final sum plus twice its carries. The last level receives a single bit and needs no adder.
- R4: `majority_o` is 1 exactly when the number of 1s is at least (N+1)/2.
- R5: When at least ceil(3N/4) inputs are 1, `majority_o` is 1. When at least ceil(3N/4) inputs are 0, `majority_o` is 0.
- R6: `supermaj_o` is 1 exactly when the number of 1s is at least ceil(3N/4) or at most floor(N/4).
- R7: With REG_OUT = 1, the outputs take the result for `data_i` on the rising edge where `in_valid` is 1. `out_valid` is 1 for the following cycle only. When `in_valid` is 0, the result outputs hold their values and `out_valid` is 0.
- R8: With REG_OUT = 0, the outputs follow `data_i` combinationally and `out_valid` equals `in_valid`.
- R9: With REG_OUT = 1, a synchronous active-high `rst` clears `count_o`, `majority_o`, `supermaj_o` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking `data_i` as valid |
| data_i | input | 2^K − 1 | Bits to be voted |
| out_valid | output | 1 | Result valid |
| count_o | output | K | Population count, one bit per level sum |
| majority_o | output | 1 | Majority value |
| supermaj_o | output | 1 | At least three quarters of the bits agree |

## Verification
The bench targets the count values that sit on each threshold: (N+1)/2 and one below it, ceil(3N/4) and one below it, and floor(N/4) and one above it. An off-by-one in the tree or in the flag compare shows up there as a wrong majority or a wrong flag. Exhaustive runs at K = 2, 3 and 4 catch a miswired carry or a broken sum chain, because any such fault produces a count that departs from the popcount for some vector. Widths K = 3 and K = 4 both take part, so a fault that depends on the number of levels cannot hide behind one particular width. Hold cycles with changing data and no strobe expose a register that captures on every cycle, and a mid-run reset exposes outputs that do not clear.

// File: rtl/fatm_pkg.sv
package fatm_pkg;

  // width of the bit vector entering level j (1-based) of a K-level tree
  function automatic int lvl_width(input int k, input int j);
    return (1 << (k - j + 1)) - 1;
  endfunction

  // start position of level j inside the flat tree bus
  function automatic int lvl_offset(input int k, input int j);
    return (1 << (k + 1)) - (1 << (k - j + 2)) - (j - 1);
  endfunction

  // total number of bits carried between all levels
  function automatic int tree_bits(input int k);
    return lvl_offset(k, k + 1);
  endfunction

  // lowest count regarded as a strong 1 vote: ceil(3n/4)
  function automatic int hi_bound(input int n);
    return (3 * n + 3) / 4;
  endfunction

  // highest count regarded as a strong 0 vote: floor(n/4)
  function automatic int lo_bound(input int n);
    return n / 4;
  endfunction

endpackage

// File: rtl/fatm_full_adder.sv
module fatm_full_adder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic s,
  output logic cout
);

  logic prop;
  logic gen;
  logic pass;

  // two XOR, two AND, one OR
  assign prop = x ^ y;
  assign s    = prop ^ cin;
  assign gen  = x & y;
  assign pass = prop & cin;
  assign cout = gen | pass;

  always_comb begin
    AST_FA_ARITH: assert ({1'b0, cout, s} == {2'b00, x} + {2'b00, y} + {2'b00, cin}); // R2
  end

endmodule

// File: rtl/fatm_chain_level.sv
module fatm_chain_level #(
  parameter int W = 7
) (
  input  logic [W-1:0]          bits_i,
  output logic                  sum_o,
  output logic [(W-1)/2-1:0]    carry_o
);

  localparam int NC = (W - 1) / 2;

  logic [NC:0] acc;

  assign acc[0] = bits_i[0];

  for (genvar i = 0; i < NC; i++) begin : g_fa
    fatm_full_adder u_fa (
      .x    (bits_i[2*i+1]),
      .y    (bits_i[2*i+2]),
      .cin  (acc[i]),
      .s    (acc[i+1]),
      .cout (carry_o[i])
    );
  end

  assign sum_o = acc[NC];

  always_comb begin
    AST_LVL_WEIGHT: assert ($countones(bits_i) == 2 * $countones(carry_o) + int'(sum_o)); // R3
  end

endmodule

// File: rtl/fatm_supermaj_flag.sv
module fatm_supermaj_flag #(
  parameter int K = 6
) (
  input  logic [K-1:0] count_i,
  output logic         flag_o
);

  import fatm_pkg::*;

  localparam int N  = (1 << K) - 1;
  localparam int HI = hi_bound(N);
  localparam int LO = lo_bound(N);
  localparam logic [K-1:0] HI_C = HI[K-1:0];
  localparam logic [K-1:0] LO_C = LO[K-1:0];

  assign flag_o = (count_i >= HI_C) || (count_i <= LO_C);

endmodule

// File: rtl/fa_tree_majority.sv
module fa_tree_majority #(
  parameter int K_LEVELS = 6,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [(1<<K_LEVELS)-2:0]   data_i,
  output logic                       out_valid,
  output logic [K_LEVELS-1:0]        count_o,
  output logic                       majority_o,
  output logic                       supermaj_o
);

  import fatm_pkg::*;

  localparam int N   = (1 << K_LEVELS) - 1;
  localparam int TOT = tree_bits(K_LEVELS);
  localparam int HI  = hi_bound(N);
  localparam int LO  = lo_bound(N);

  // all level inputs side by side: level 1 is data_i, level j+1 is level j carries
  logic [TOT-1:0]      tree;
  logic [K_LEVELS-1:0] cnt;
  logic                flag;

  assign tree[lvl_width(K_LEVELS, 1)-1:0] = data_i;

  for (genvar j = 1; j < K_LEVELS; j++) begin : g_lvl
    localparam int WJ  = lvl_width(K_LEVELS, j);
    localparam int OJ  = lvl_offset(K_LEVELS, j);
    localparam int ONX = lvl_offset(K_LEVELS, j + 1);
    localparam int WNX = lvl_width(K_LEVELS, j + 1);

    fatm_chain_level #(.W(WJ)) u_lvl (
      .bits_i  (tree[OJ +: WJ]),
      .sum_o   (cnt[j-1]),
      .carry_o (tree[ONX +: WNX])
    );
  end

  // the last level holds a single weight 2^(K-1) bit: it is the top count bit
  assign cnt[K_LEVELS-1] = tree[lvl_offset(K_LEVELS, K_LEVELS)];

  fatm_supermaj_flag #(.K(K_LEVELS)) u_flag (
    .count_i (cnt),
    .flag_o  (flag)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid  <= 1'b0;
        count_o    <= '0;
        majority_o <= 1'b0;
        supermaj_o <= 1'b0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          count_o    <= cnt;
          majority_o <= cnt[K_LEVELS-1];
          supermaj_o <= flag;
        end
      end
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(count_o) && $stable(majority_o) && $stable(supermaj_o))); // R7
    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (int'(count_o) == $past($countones(data_i)))); // R1
    AST_STRONG_ONE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && $countones(data_i) >= HI) |=> (majority_o && supermaj_o)); // R5
    AST_STRONG_ZERO: assert property (@(posedge clk) disable iff (rst)
      (in_valid && $countones(data_i) <= LO) |=> (!majority_o && supermaj_o)); // R5
  end else begin : g_comb
    assign out_valid  = in_valid;
    assign count_o    = cnt;
    assign majority_o = cnt[K_LEVELS-1];
    assign supermaj_o = flag;

    always_comb begin
      AST_COMB_MAJ: assert (majority_o == ($countones(data_i) >= (N + 1) / 2)); // R4
    end
  end

endmodule

// File: tb/fa_tree_majority_tb_top.sv
module fa_tree_majority_tb_top;

  logic clk = 1'b0;
  logic rst;
  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // K=6 registered
  logic        vld6;
  logic [62:0] d6;
  logic        ov6, mj6, sm6;
  logic [5:0]  c6;
  // K=4 registered
  logic        vld4;
  logic [14:0] d4;
  logic        ov4, mj4, sm4;
  logic [3:0]  c4;
  // K=3 combinational
  logic        vld3;
  logic [6:0]  d3;
  logic        ov3, mj3, sm3;
  logic [2:0]  c3;
  // K=2 combinational
  logic        vld2;
  logic [2:0]  d2;
  logic        ov2, mj2, sm2;
  logic [1:0]  c2;

  fa_tree_majority #(.K_LEVELS(6), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(vld6), .data_i(d6),
    .out_valid(ov6), .count_o(c6), .majority_o(mj6), .supermaj_o(sm6));
  fa_tree_majority #(.K_LEVELS(4), .REG_OUT(1'b1)) dut_k4 (
    .clk(clk), .rst(rst), .in_valid(vld4), .data_i(d4),
    .out_valid(ov4), .count_o(c4), .majority_o(mj4), .supermaj_o(sm4));
  fa_tree_majority #(.K_LEVELS(3), .REG_OUT(1'b0)) dut_k3 (
    .clk(clk), .rst(rst), .in_valid(vld3), .data_i(d3),
    .out_valid(ov3), .count_o(c3), .majority_o(mj3), .supermaj_o(sm3));
  fa_tree_majority #(.K_LEVELS(2), .REG_OUT(1'b0)) dut_k2 (
    .clk(clk), .rst(rst), .in_valid(vld2), .data_i(d2),
    .out_valid(ov2), .count_o(c2), .majority_o(mj2), .supermaj_o(sm2));

  function automatic int exp_maj(input int n, input int ones);
    return (ones >= (n + 1) / 2) ? 1 : 0;
  endfunction

  function automatic int exp_flag(input int n, input int ones);
    return ((ones >= (3 * n + 3) / 4) || (ones <= n / 4)) ? 1 : 0;
  endfunction

  function automatic logic [62:0] pattern(input int p, input int rot);
    logic [62:0] v = '0;
    for (int i = 0; i < p; i++) v[(i + rot) % 63] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // checks count, majority and flag against the popcount reference
  task automatic chk_result(input string tag, input int n, input int ones,
                            input int cnt, input int mj, input int sm);
    chk({tag, " R1 R2 R3 count"}, cnt, ones);
    chk({tag, " R4 majority"}, mj, exp_maj(n, ones));
    chk({tag, " R6 flag"}, sm, exp_flag(n, ones));
  endtask

  // drive one strobed vector into the K=6 unit; call at a falling edge
  task automatic run6(input logic [62:0] v);
    d6 = v;
    vld6 = 1'b1;
    @(negedge clk);
    chk("K6 R7 valid", int'(ov6), 1);
    chk_result("K6", 63, $countones(v), int'(c6), int'(mj6), int'(sm6));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [62:0] rv;
    void'($urandom(32'h5eed_0042));
    rst = 1'b1;
    vld6 = 0; vld4 = 0; vld3 = 0; vld2 = 0;
    d6 = '0; d4 = '0; d3 = '0; d2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 reset out_valid", int'(ov6), 0);
    chk("R9 reset count", int'(c6), 0);
    chk("R9 reset majority", int'(mj6), 0);
    chk("R9 reset flag", int'(sm6), 0);
    chk("R9 reset K4 count", int'(c4), 0);
    rst = 1'b0;

    // R8: combinational units, exhaustive
    for (int v = 0; v < 128; v++) begin
      d3 = v[6:0];
      vld3 = v[0];
      #1;
      chk("K3 R8 valid", int'(ov3), v & 1);
      chk_result("K3 R8", 7, $countones(v[6:0]), int'(c3), int'(mj3), int'(sm3));
    end
    for (int v = 0; v < 8; v++) begin
      d2 = v[2:0];
      vld2 = 1'b1;
      #1;
      chk_result("K2 R8", 3, $countones(v[2:0]), int'(c2), int'(mj2), int'(sm2));
    end

    // K=4 registered, exhaustive
    @(negedge clk);
    for (int v = 0; v < 32768; v++) begin
      d4 = v[14:0];
      vld4 = 1'b1;
      @(negedge clk);
      chk_result("K4", 15, $countones(v[14:0]), int'(c4), int'(mj4), int'(sm4));
    end
    vld4 = 1'b0;

    // directed threshold cases for K=6: (n+1)/2=32, ceil(3n/4)=48, floor(n/4)=15
    run6('0);
    run6({63{1'b1}});
    run6(pattern(32, 5));
    run6(pattern(31, 9));
    run6(pattern(48, 17));
    chk("K6 R5 48 ones gives 1", int'(mj6), 1);
    run6(pattern(47, 3));
    run6(pattern(15, 40));
    chk("K6 R5 48 zeros gives 0", int'(mj6), 0);
    run6(pattern(16, 22));

    // random vectors with varied density
    for (int t = 0; t < 3000; t++) begin
      rv = {$urandom, $urandom};
      case (t % 4)
        1: rv = rv & {$urandom, $urandom};
        2: rv = rv | {$urandom, $urandom};
        3: rv = rv & {$urandom, $urandom} & {$urandom, $urandom};
        default: ;
      endcase
      run6(rv);
    end

    // R7 hold: known result, then no strobe with different data
    run6(pattern(50, 0));
    d6 = pattern(3, 7);
    vld6 = 1'b0;
    @(negedge clk);
    chk("K6 R7 idle out_valid", int'(ov6), 0);
    chk("K6 R7 hold count", int'(c6), 50);
    chk("K6 R7 hold majority", int'(mj6), 1);
    chk("K6 R7 hold flag", int'(sm6), 1);
    @(negedge clk);
    chk("K6 R7 hold count second cycle", int'(c6), 50);

    // R9 mid-run reset
    run6(pattern(40, 2));
    rst = 1'b1;
    vld6 = 1'b1;
    @(negedge clk);
    chk("R9 mid reset count", int'(c6), 0);
    chk("R9 mid reset out_valid", int'(ov6), 0);
    chk("R9 mid reset majority", int'(mj6), 0);
    rst = 1'b0;
    vld6 = 1'b0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule